// File: doc/BRIEF.md
# Management-Bus PHY Status Poller

This block is the management-bus master of an eight-port switch. It walks through the attached PHYs one at a time and issues a clause-22 style MDIO read frame to each. Every PHY is asked for the same register, whose 5-bit address comes from configuration, because different PHYs report their parallel-detection result in different registers. From the 16-bit value it reads, the block resolves the port's speed and duplex. It then hands the result to the switch core together with a one-cycle update strobe.

Configuration can move the PHY address range up by eight, so the first PHY is not at address 0, which some PHYs treat as broadcast. It can also walk the ports in descending order to match a quad PHY pinned the other way round, and it can select a very slow management clock of roughly 17 kHz. A port falls back to its configured default speed and duplex when the PHY reports that auto-negotiation did not complete. While polling is switched off, every port shows its defaults. After each full pass over the eight ports the engine waits a programmable number of cycles and then starts again.

Top module: `mdio_status_poller`

## Requirements
- R1: Port p is read at PHY address p when `cfg_base_hi` is 0, and at PHY address 8+p when `cfg_base_hi` is 1.
- R2: Within a pass, ports are read in ascending order 0..7 when `cfg_reverse` is 0 and in descending order 7..0 when it is 1. Each pass starts from the first port in that order.
- R3: Each read frame is, MSB first, 32 ones, start bits 0 then 1, opcode bits 1 then 0, 5-bit PHY address, and 5-bit register address. The master then releases MDIO (`mdio_oe` low) for 2 turnaround bits and 16 data bits. `mdio_oe` changes only on the cycle in which MDC falls, and each data bit is sampled when MDC rises.
- R4: The register address in every frame equals `cfg_reg_addr`.
- R5: MDC high and low phases each last FAST_HALF clock cycles when `cfg_slow` is 0 and SLOW_HALF cycles when it is 1. The defaults give about 2.5 MHz and about 17 kHz from 250 MHz.
- R6: When bit 2 (aneg complete) of the read value is 1, the port speed takes bit 0 (1 = 100 Mb/s) and the duplex takes bit 1 (1 = full).
- R7: When bit 2 of the read value is 0, the port takes `dflt_speed[p]` and `dflt_duplex[p]` as they stand at the update.
- R8: While `mdio_en` is 0, `port_speed` and `port_duplex` equal the default inputs, `port_valid` is 0, and from the next cycle MDC and `mdio_oe` are low.
- R9: `port_valid` is one-hot or zero. Bit p pulses for one cycle after the frame for port p completes, with that port's new result on the outputs in the same cycle.
- R10: After the last port of a pass is updated, no new frame starts for at least `cfg_gap` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdio_en | input | 1 | Enable polling; low forces defaults |
| cfg_reg_addr | input | 5 | Register address read from every PHY |
| cfg_base_hi | input | 1 | Offset PHY addresses by 8 |
| cfg_reverse | input | 1 | Walk ports in descending order |
| cfg_slow | input | 1 | Select slow MDC divider |
| cfg_gap | input | GAP_W | Idle cycles between passes |
| dflt_speed | input | NUM_PORTS | Per-port default speed (1 = 100 Mb/s) |
| dflt_duplex | input | NUM_PORTS | Per-port default duplex (1 = full) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| port_speed | output | NUM_PORTS | Resolved per-port speed |
| port_duplex | output | NUM_PORTS | Resolved per-port duplex |
| port_valid | output | NUM_PORTS | One-cycle update strobe per port |

## Verification
A bit counter that drifts by one shows within a single frame. The address and register fields come out shifted, or `mdio_oe` stays asserted into the turnaround, and the PHY model in the bench decodes the frame bit by bit as it goes. A wrong port index or a wrong order shows at the next `port_valid` pulse, which names a port other than the one whose PHY was just read. A wrong decode of the status bits shows in the speed and duplex presented with that same pulse. Errors in the divider or the gap counter show as an MDC phase of the wrong length, or as a frame starting too early after a pass. Both are measured on every clock.

// File: rtl/mdio_poll_pkg.sv
package mdio_poll_pkg;
    localparam int PHY_ADDR_W = 5;
    localparam int REG_ADDR_W = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_LEN    = 32;
    localparam int HDR_LEN    = PRE_LEN + 4 + PHY_ADDR_W + REG_ADDR_W;
    localparam int TA_LEN     = 2;
    localparam int FRAME_LEN  = HDR_LEN + TA_LEN + DATA_W;
    localparam int BIT_SPEED  = 0;
    localparam int BIT_DUPLEX = 1;
    localparam int BIT_ANEG   = 2;

    typedef enum logic [1:0] {
        SEQ_START = 2'd0,
        SEQ_WAIT  = 2'd1,
        SEQ_GAP   = 2'd2
    } seq_state_e;

    typedef enum logic {
        FRM_IDLE = 1'b0,
        FRM_RUN  = 1'b1
    } frm_state_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int FAST_HALF = 50,
    parameter int SLOW_HALF = 7353
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic slow,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int MAX_HALF = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
    localparam int CNT_W    = $clog2(MAX_HALF + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } mdc_st_t;

    mdc_st_t st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic             wrap;

    assign lim  = slow ? CNT_W'(SLOW_HALF - 1) : CNT_W'(FAST_HALF - 1);
    assign wrap = (st_q.cnt >= lim);

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc      = st_q.mdc;
    assign rise_stb = en && wrap && !st_q.mdc;
    assign fall_stb = en && wrap &&  st_q.mdc;

    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc);
    p_rise_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb && en) |=> mdc);
    p_fall_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !mdc);
endmodule

// File: rtl/mdio_read_frame.sv
module mdio_read_frame
    import mdio_poll_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  start,
    input  logic                  rise_stb,
    input  logic                  fall_stb,
    input  logic [PHY_ADDR_W-1:0] phy_addr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  mdio_i,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);

    typedef struct packed {
        frm_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [HDR_LEN-1:0]  tx;
        logic [DATA_W-1:0]   rx;
        logic                oe;
        logic                o;
        logic                done;
    } frm_st_t;

    frm_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!en) begin
            st_d.st  = FRM_IDLE;
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
            st_d.o   = 1'b0;
        end else begin
            case (st_q.st)
                FRM_IDLE: begin
                    if (start) begin
                        st_d.tx  = {{PRE_LEN{1'b1}}, 2'b01, 2'b10, phy_addr, reg_addr};
                        st_d.cnt = '0;
                        st_d.rx  = '0;
                        st_d.st  = FRM_RUN;
                    end
                end
                FRM_RUN: begin
                    if (fall_stb && (st_q.cnt < CNT_W'(FRAME_LEN))) begin
                        if (st_q.cnt < CNT_W'(HDR_LEN)) begin
                            st_d.oe = 1'b1;
                            st_d.o  = st_q.tx[HDR_LEN-1];
                            st_d.tx = {st_q.tx[HDR_LEN-2:0], 1'b0};
                        end else begin
                            st_d.oe = 1'b0;
                            st_d.o  = 1'b0;
                        end
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                    if (rise_stb && (st_q.cnt > CNT_W'(HDR_LEN + TA_LEN))) begin
                        st_d.rx = {st_q.rx[DATA_W-2:0], mdio_i};
                        if (st_q.cnt == CNT_W'(FRAME_LEN)) begin
                            st_d.done = 1'b1;
                            st_d.st   = FRM_IDLE;
                        end
                    end
                end
                default: st_d.st = FRM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdio_o  = st_q.o;
    assign mdio_oe = st_q.oe;
    assign done    = st_q.done;
    assign rd_data = st_q.rx;

    // R3: master must not drive during turnaround or data phase
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == FRM_RUN && st_q.cnt > CNT_W'(HDR_LEN)) |-> !mdio_oe);
    p_oe_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (mdio_oe != $past(mdio_oe))) |-> $past(fall_stb));
    p_done_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mdio_oe);
endmodule

// File: rtl/mdio_status_poller.sv
module mdio_status_poller
    import mdio_poll_pkg::*;
#(
    parameter int NUM_PORTS    = 8,
    parameter int FAST_HALF    = 50,
    parameter int SLOW_HALF    = 7353,
    parameter int GAP_W        = 16,
    parameter int BASE_HI_ADDR = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mdio_en,
    input  logic [REG_ADDR_W-1:0] cfg_reg_addr,
    input  logic                  cfg_base_hi,
    input  logic                  cfg_reverse,
    input  logic                  cfg_slow,
    input  logic [GAP_W-1:0]      cfg_gap,
    input  logic [NUM_PORTS-1:0]  dflt_speed,
    input  logic [NUM_PORTS-1:0]  dflt_duplex,
    output logic                  mdc,
    input  logic                  mdio_i,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic [NUM_PORTS-1:0]  port_speed,
    output logic [NUM_PORTS-1:0]  port_duplex,
    output logic [NUM_PORTS-1:0]  port_valid
);
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PORTS - 1);

    typedef struct packed {
        seq_state_e           st;
        logic [IDX_W-1:0]     idx;
        logic [GAP_W-1:0]     gap;
        logic [NUM_PORTS-1:0] spd;
        logic [NUM_PORTS-1:0] dup;
        logic [NUM_PORTS-1:0] vld;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic                  rise_stb, fall_stb;
    logic                  frm_start, frm_done;
    logic [DATA_W-1:0]     rd_data;
    logic [IDX_W-1:0]      cur_port;
    logic [PHY_ADDR_W-1:0] cur_phy;
    logic                  unused_rd;

    assign unused_rd = ^rd_data[DATA_W-1:BIT_ANEG+1];
    assign cur_port  = cfg_reverse ? (LAST_IDX - st_q.idx) : st_q.idx;
    assign cur_phy   = PHY_ADDR_W'(cur_port)
                     + (cfg_base_hi ? PHY_ADDR_W'(BASE_HI_ADDR) : '0);

    mdio_mdc_gen #(
        .FAST_HALF (FAST_HALF),
        .SLOW_HALF (SLOW_HALF)
    ) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mdio_en),
        .slow     (cfg_slow),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_read_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mdio_en),
        .start    (frm_start),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .phy_addr (cur_phy),
        .reg_addr (cfg_reg_addr),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (frm_done),
        .rd_data  (rd_data)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = '0;
        frm_start = 1'b0;
        if (!mdio_en) begin
            st_d.st  = SEQ_START;
            st_d.idx = '0;
            st_d.gap = '0;
        end else begin
            case (st_q.st)
                SEQ_START: begin
                    frm_start = 1'b1;
                    st_d.st   = SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (frm_done) begin
                        if (rd_data[BIT_ANEG]) begin
                            st_d.spd[cur_port] = rd_data[BIT_SPEED];
                            st_d.dup[cur_port] = rd_data[BIT_DUPLEX];
                        end else begin
                            st_d.spd[cur_port] = dflt_speed[cur_port];
                            st_d.dup[cur_port] = dflt_duplex[cur_port];
                        end
                        st_d.vld[cur_port] = 1'b1;
                        if (st_q.idx == LAST_IDX) begin
                            st_d.idx = '0;
                            st_d.gap = cfg_gap;
                            st_d.st  = SEQ_GAP;
                        end else begin
                            st_d.idx = st_q.idx + 1'b1;
                            st_d.st  = SEQ_START;
                        end
                    end
                end
                SEQ_GAP: begin
                    if (st_q.gap == '0) st_d.st = SEQ_START;
                    else                st_d.gap = st_q.gap - 1'b1;
                end
                default: st_d.st = SEQ_START;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign port_speed  = mdio_en ? st_q.spd : dflt_speed;
    assign port_duplex = mdio_en ? st_q.dup : dflt_duplex;
    assign port_valid  = st_q.vld;

    p_valid_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_valid));
    p_valid_after_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid != '0) |-> $past(frm_done));
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_en |=> (port_valid == '0 && !mdio_oe));
    p_gap_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == SEQ_GAP) |-> !mdio_oe);
endmodule

// File: tb/tb_mdio_status_poller.sv
module tb_mdio_status_poller;
    localparam int NP = 8;
    localparam int FH = 2;
    localparam int SH = 5;
    localparam int GW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mdio_en = 1'b0;
    logic [4:0]    cfg_reg_addr = '0;
    logic          cfg_base_hi = 1'b0;
    logic          cfg_reverse = 1'b0;
    logic          cfg_slow = 1'b0;
    logic [GW-1:0] cfg_gap = '0;
    logic [NP-1:0] dflt_speed = 8'hA5;
    logic [NP-1:0] dflt_duplex = 8'h3C;
    logic          mdc, mdio_i, mdio_o, mdio_oe;
    logic [NP-1:0] port_speed, port_duplex, port_valid;

    always #2 clk = ~clk;

    mdio_status_poller #(.NUM_PORTS(NP), .FAST_HALF(FH), .SLOW_HALF(SH), .GAP_W(GW)) dut (
        .clk(clk), .rst_n(rst_n), .mdio_en(mdio_en), .cfg_reg_addr(cfg_reg_addr),
        .cfg_base_hi(cfg_base_hi), .cfg_reverse(cfg_reverse), .cfg_slow(cfg_slow),
        .cfg_gap(cfg_gap), .dflt_speed(dflt_speed), .dflt_duplex(dflt_duplex),
        .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .port_speed(port_speed), .port_duplex(port_duplex), .port_valid(port_valid));

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int scans = 0;
    logic [15:0] phy_reg [32];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural PHY and reference model, all sampled on the falling clock edge
    logic prev_mdc = 0, prev_oe = 0, prev_en = 0;
    bit   infrm = 0, have_last = 0;
    int   bitpos = 0, k = 0, run = 0, toggles = 0, t_last = 0, cur_phy = 0;
    logic fbits [64];
    int   exp_q [$];

    function automatic int exp_port(int i);
        return cfg_reverse ? (NP - 1 - i) : i;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!mdio_en) begin
                infrm = 0; k = 0; toggles = 0; run = 0; have_last = 0;
                exp_q.delete();
                mdio_i = 1'b1;
                check("R8 speed", port_speed, dflt_speed);
                check("R8 duplex", port_duplex, dflt_duplex);
                if (!prev_en) begin
                    check("R8 mdc", mdc, 0);
                    check("R8 oe", mdio_oe, 0);
                    check("R8 valid", port_valid, 0);
                end
            end else begin
                // R5: phase length
                if (mdc != prev_mdc) begin
                    if (toggles > 0) check("R5 mdc phase", run, cfg_slow ? SH : FH);
                    run = 1; toggles++;
                end else run++;
                // R3: oe only moves when mdc falls
                if (prev_en && mdio_oe != prev_oe)
                    check("R3 oe on mdc fall", {prev_mdc, mdc}, 2'b10);
                if (mdc && !prev_mdc) begin
                    if (!infrm && mdio_oe) begin
                        infrm = 1; bitpos = 0;
                        if (have_last) begin
                            check("R10 gap respected", (cyc - t_last) >= cfg_gap, 1);
                            have_last = 0;
                        end
                    end
                    if (infrm) begin
                        if (bitpos < 46) begin
                            if (!mdio_oe) check("R3 driven header", 0, 1);
                            fbits[bitpos] = mdio_o;
                        end else if (mdio_oe) check("R3 released", mdio_oe, 0);
                        bitpos++;
                        if (bitpos == 46) begin
                            logic [31:0] pre; logic [3:0] so; logic [4:0] pa, ra;
                            for (int i = 0; i < 32; i++) pre[31-i] = fbits[i];
                            for (int i = 0; i < 4; i++) so[3-i] = fbits[32+i];
                            for (int i = 0; i < 5; i++) pa[4-i] = fbits[36+i];
                            for (int i = 0; i < 5; i++) ra[4-i] = fbits[41+i];
                            check("R3 preamble", pre, 32'hFFFF_FFFF);
                            check("R3 start/op", so, 4'b0110);
                            check("R1/R2 phy address", pa, (cfg_base_hi ? 8 : 0) + exp_port(k));
                            check("R4 register address", ra, cfg_reg_addr);
                            cur_phy = pa;
                        end
                        if (bitpos == 64) begin
                            logic [15:0] v; int p, s, d;
                            v = phy_reg[cur_phy];
                            p = exp_port(k);
                            s = v[2] ? v[0] : dflt_speed[p];
                            d = v[2] ? v[1] : dflt_duplex[p];
                            exp_q.push_back(p * 4 + s * 2 + d);
                            infrm = 0;
                            k = (k + 1) % NP;
                        end
                    end
                end
                if (!mdc && prev_mdc)
                    mdio_i = (infrm && bitpos >= 48 && bitpos < 64) ? phy_reg[cur_phy][63 - bitpos] : 1'b1;
                if (port_valid != 0) begin
                    check("R9 valid onehot", $onehot(port_valid), 1);
                    if (exp_q.size() == 0) check("R9 valid without frame", port_valid, 0);
                    else begin
                        int e, p;
                        e = exp_q.pop_front();
                        p = e / 4;
                        check("R9 valid port", port_valid, 1 << p);
                        check("R6/R7 speed", port_speed[p], (e >> 1) & 1);
                        check("R6/R7 duplex", port_duplex[p], e & 1);
                        if (p == exp_port(NP - 1)) begin
                            scans++; have_last = 1; t_last = cyc;
                        end
                    end
                end
            end
        end
        prev_mdc = mdc; prev_oe = mdio_oe; prev_en = mdio_en;
    end

    task automatic fill(logic [15:0] seed, int b);
        for (int a = 0; a < 32; a++) phy_reg[a] = 16'(a * 16'h2F1B) ^ seed;
        phy_reg[b + 1][2] = 1'b1; phy_reg[b + 1][1:0] = 2'b01;
        phy_reg[b + 2][2] = 1'b1; phy_reg[b + 2][1:0] = 2'b10;
        phy_reg[b + 3][2] = 1'b0;
        phy_reg[b + 5][2] = 1'b0;
    endtask

    task automatic run_scans(int n);
        int target;
        target = scans + n;
        @(posedge clk); #1 mdio_en = 1'b1;
        while (scans < target) @(posedge clk);
        @(posedge clk); #1 mdio_en = 1'b0;
        repeat (5) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        for (int a = 0; a < 32; a++) phy_reg[a] = '0;
        mdio_i = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset valid", port_valid, 0);
        check("R8 reset mdc", mdc, 0);
        check("R8 reset oe", mdio_oe, 0);
        check("R8 reset speed", port_speed, 8'hA5);
        // A: ascending, base 0, fast clock
        @(posedge clk); #1;
        cfg_reg_addr = 5'h11; cfg_gap = 8'd20; fill(16'h5A3C, 0);
        run_scans(2);
        // B: descending, base 8
        #1 cfg_base_hi = 1; cfg_reverse = 1; cfg_reg_addr = 5'h1F; cfg_gap = 8'd40;
        fill(16'hC381, 8); dflt_speed = 8'h0F; dflt_duplex = 8'hF0;
        run_scans(2);
        // C: slow clock, base 0, descending, new defaults
        #1 cfg_base_hi = 0; cfg_slow = 1; cfg_reg_addr = 5'h00; cfg_gap = 8'd3;
        fill(16'h1E66, 0); dflt_speed = 8'h96; dflt_duplex = 8'h69;
        run_scans(1);
        // disabled: defaults follow input changes (R8)
        #1 dflt_speed = 8'h12; dflt_duplex = 8'hED;
        @(negedge clk);
        check("R8 follow speed", port_speed, 8'h12);
        check("R8 follow duplex", port_duplex, 8'hED);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule